// File: doc/BRIEF.md
# Burst Memory Controller with Access Latency

This block places an on-chip word array behind a bus slave port that follows a simplified AXI-lite style. Writes use three channels: a burst request (start address and beat count), a write-data channel and a write-response channel. Reads use two channels: a burst request and a read-data channel that carries a response code and an end-of-burst flag. Every channel transfers only on a cycle where its valid and ready are both high. A write state machine and a read state machine run independently of each other. Each one serves a single burst at a time.

Every beat of a burst waits a programmable number of cycles before its memory access completes. The wait comes either from the `lat_cfg` input, sampled when the burst request is accepted, or from a fixed parameter. Each beat's address is checked against the populated depth. An out-of-range beat touches no storage and produces an error code. Data width, address width, depth, burst-length width and latency width are all parameters.

Top module: `burst_mem_ctrl`

## Requirements
- R1: A write burst stores beat i at address start+i. After its final beat it produces exactly one response, which is 2'b00 (OK) when every beat was in range.
- R2: A read burst returns the word stored at start+i on beat i. `r_last` is 1 on the final beat and 0 on all earlier beats.
- R3: With latency L (0..15), `r_valid` rises L+1 cycles after the read-request handshake or after the previous read-beat handshake. `w_ready` (for the next beat) or `b_valid` (after the final beat) rises L+1 cycles after each write-beat handshake. L is sampled at the request handshake, so later changes to `lat_cfg` have no effect on a burst already accepted.
- R4: A write beat whose address is DEPTH or above is not stored. The burst response is 2'b10 (slave error) if any of its beats was out of range.
- R5: A read beat whose address is DEPTH or above returns all-zero data with `r_resp` = 2'b10. An in-range read beat returns `r_resp` = 2'b00.
- R6: `aw_len` and `ar_len` hold the beat count minus one (0 means 1 beat, 15 means 16 beats). The address advances by one word per beat and wraps modulo 2^ADDR_W.
- R7: Once `b_valid` or `r_valid` is high, it stays high with unchanged response, data and last flag until the matching ready is seen.
- R8: `aw_ready` stays low from the write-request handshake until the response handshake. `ar_ready` stays low from the read-request handshake until the final read-beat handshake.
- R9: A read burst and a write burst can be in progress at the same time, and each completes correctly.
- R10: Synchronous active-high `rst` clears `b_valid` and `r_valid` and returns both machines to idle, with `aw_ready` and `ar_ready` high. It leaves the stored words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lat_cfg | input | LAT_W | Access latency in cycles, sampled at request handshake |
| aw_valid | input | 1 | Write burst request valid |
| aw_ready | output | 1 | Write burst request accepted |
| aw_addr | input | ADDR_W | Write burst start address (words) |
| aw_len | input | LEN_W | Write beat count minus one |
| w_valid | input | 1 | Write data valid |
| w_ready | output | 1 | Write data accepted |
| w_data | input | DATA_W | Write data word |
| b_valid | output | 1 | Write response valid |
| b_ready | input | 1 | Write response accepted |
| b_resp | output | 2 | Write response: 00 OK, 10 error |
| ar_valid | input | 1 | Read burst request valid |
| ar_ready | output | 1 | Read burst request accepted |
| ar_addr | input | ADDR_W | Read burst start address (words) |
| ar_len | input | LEN_W | Read beat count minus one |
| r_valid | output | 1 | Read data valid |
| r_ready | input | 1 | Read data accepted |
| r_data | output | DATA_W | Read data word |
| r_resp | output | 2 | Read response: 00 OK, 10 error |
| r_last | output | 1 | Final beat of the read burst |

## Verification
Read data is due L+1 cycles after the request handshake, and again L+1 cycles after each beat is taken. Write readiness for the next beat, or the write response after the final beat, is due L+1 cycles after each beat is accepted. The bench drives inputs and samples outputs on falling edges. After each handshake it counts falling edges until the expected valid or ready appears, and compares that count with L+1 for the latency of that burst. Responses, data and last flags are compared in the same cycle the valid is first seen. They are compared again on every cycle the bench deliberately withholds ready.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
   localparam logic [1:0] RESP_OK  = 2'b00;
   localparam logic [1:0] RESP_ERR = 2'b10;

   typedef enum logic [1:0] {W_IDLE, W_DATA, W_WAIT, W_RESP} wr_state_e;
   typedef enum logic [1:0] {R_IDLE, R_WAIT, R_DATA} rd_state_e;
endpackage

// File: rtl/bmc_lat_timer.sv
module bmc_lat_timer #(
   parameter int LAT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load,
   input  logic [LAT_W-1:0] load_val,
   output logic             expired
);
   logic [LAT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)              cnt_q <= '0;
      else if (load)        cnt_q <= load_val;
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/bmc_mem.sv
module bmc_mem #(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int DEPTH  = 200
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   output logic              w_hit,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata,
   output logic              r_hit
);
   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam bit FULL  = (DEPTH == (1 << ADDR_W));

   logic [DATA_W-1:0] store [DEPTH];
   logic [IDX_W-1:0]  widx, ridx;

   generate
      if (FULL) begin : g_full
         assign w_hit = 1'b1;
         assign r_hit = 1'b1;
      end else begin : g_partial
         localparam logic [ADDR_W:0] LIMIT = (ADDR_W+1)'(DEPTH);
         assign w_hit = ({1'b0, waddr} < LIMIT);
         assign r_hit = ({1'b0, raddr} < LIMIT);
      end
   endgenerate

   assign widx = waddr[IDX_W-1:0];
   assign ridx = raddr[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (we && w_hit) store[widx] <= wdata;
   end

   assign rdata = r_hit ? store[ridx] : '0;
endmodule

// File: rtl/bmc_wr_fsm.sv
module bmc_wr_fsm
   import bmc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int LEN_W  = 4,
   parameter int LAT_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [LAT_W-1:0]  lat_val,
   input  logic              aw_valid,
   output logic              aw_ready,
   input  logic [ADDR_W-1:0] aw_addr,
   input  logic [LEN_W-1:0]  aw_len,
   input  logic              w_valid,
   output logic              w_ready,
   input  logic [DATA_W-1:0] w_data,
   output logic              b_valid,
   input  logic              b_ready,
   output logic [1:0]        b_resp,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_hit
);
   wr_state_e         state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  left_q;
   logic [LAT_W-1:0]  lat_q;
   logic [DATA_W-1:0] data_q;
   logic              err_q;
   logic              t_load, t_expired;

   assign aw_ready = (state_q == W_IDLE);
   assign w_ready  = (state_q == W_DATA);
   assign b_valid  = (state_q == W_RESP);
   assign b_resp   = err_q ? RESP_ERR : RESP_OK;

   assign t_load    = w_valid && w_ready;
   assign mem_we    = (state_q == W_WAIT) && t_expired;
   assign mem_addr  = addr_q;
   assign mem_wdata = data_q;

   bmc_lat_timer #(.LAT_W(LAT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load),
      .load_val (lat_q),
      .expired  (t_expired)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= W_IDLE;
         addr_q  <= '0;
         left_q  <= '0;
         lat_q   <= '0;
         data_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         case (state_q)
            W_IDLE: if (aw_valid) begin
               addr_q  <= aw_addr;
               left_q  <= aw_len;
               lat_q   <= lat_val;
               err_q   <= 1'b0;
               state_q <= W_DATA;
            end
            W_DATA: if (w_valid) begin
               data_q  <= w_data;
               state_q <= W_WAIT;
            end
            W_WAIT: if (t_expired) begin
               if (!mem_hit) err_q <= 1'b1;
               if (left_q == '0) begin
                  state_q <= W_RESP;
               end else begin
                  addr_q  <= addr_q + 1'b1;
                  left_q  <= left_q - 1'b1;
                  state_q <= W_DATA;
               end
            end
            W_RESP: if (b_ready) state_q <= W_IDLE;
            default: state_q <= W_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/bmc_rd_fsm.sv
module bmc_rd_fsm
   import bmc_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int ADDR_W = 8,
   parameter int LEN_W  = 4,
   parameter int LAT_W  = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [LAT_W-1:0]  lat_val,
   input  logic              ar_valid,
   output logic              ar_ready,
   input  logic [ADDR_W-1:0] ar_addr,
   input  logic [LEN_W-1:0]  ar_len,
   output logic              r_valid,
   input  logic              r_ready,
   output logic [DATA_W-1:0] r_data,
   output logic [1:0]        r_resp,
   output logic              r_last,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_hit
);
   rd_state_e         state_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  left_q;
   logic [LAT_W-1:0]  lat_q;
   logic [DATA_W-1:0] data_q;
   logic              err_q, last_q;
   logic              t_load, t_expired;
   logic [LAT_W-1:0]  t_val;

   assign ar_ready = (state_q == R_IDLE);
   assign r_valid  = (state_q == R_DATA);
   assign r_data   = data_q;
   assign r_resp   = err_q ? RESP_ERR : RESP_OK;
   assign r_last   = last_q;
   assign mem_addr = addr_q;

   assign t_load = (ar_valid && ar_ready) ||
                   (r_valid && r_ready && (left_q != '0));
   assign t_val  = (state_q == R_IDLE) ? lat_val : lat_q;

   bmc_lat_timer #(.LAT_W(LAT_W)) u_timer (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load),
      .load_val (t_val),
      .expired  (t_expired)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= R_IDLE;
         addr_q  <= '0;
         left_q  <= '0;
         lat_q   <= '0;
         data_q  <= '0;
         err_q   <= 1'b0;
         last_q  <= 1'b0;
      end else begin
         case (state_q)
            R_IDLE: if (ar_valid) begin
               addr_q  <= ar_addr;
               left_q  <= ar_len;
               lat_q   <= lat_val;
               state_q <= R_WAIT;
            end
            R_WAIT: if (t_expired) begin
               data_q  <= mem_rdata;
               err_q   <= !mem_hit;
               last_q  <= (left_q == '0);
               state_q <= R_DATA;
            end
            R_DATA: if (r_ready) begin
               if (left_q == '0) begin
                  state_q <= R_IDLE;
               end else begin
                  addr_q  <= addr_q + 1'b1;
                  left_q  <= left_q - 1'b1;
                  state_q <= R_WAIT;
               end
            end
            default: state_q <= R_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/burst_mem_ctrl.sv
module burst_mem_ctrl #(
   parameter int DATA_W        = 32,
   parameter int ADDR_W        = 8,
   parameter int DEPTH         = 200,
   parameter int LEN_W         = 4,
   parameter int LAT_W         = 4,
   parameter bit LAT_FROM_PORT = 1'b1,
   parameter int LAT_CYC       = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [LAT_W-1:0]  lat_cfg,
   input  logic              aw_valid,
   output logic              aw_ready,
   input  logic [ADDR_W-1:0] aw_addr,
   input  logic [LEN_W-1:0]  aw_len,
   input  logic              w_valid,
   output logic              w_ready,
   input  logic [DATA_W-1:0] w_data,
   output logic              b_valid,
   input  logic              b_ready,
   output logic [1:0]        b_resp,
   input  logic              ar_valid,
   output logic              ar_ready,
   input  logic [ADDR_W-1:0] ar_addr,
   input  logic [LEN_W-1:0]  ar_len,
   output logic              r_valid,
   input  logic              r_ready,
   output logic [DATA_W-1:0] r_data,
   output logic [1:0]        r_resp,
   output logic              r_last
);
   generate
      if (DEPTH < 1 || DEPTH > (1 << ADDR_W)) begin : g_bad_depth
         $error("DEPTH must lie in 1..2**ADDR_W");
      end
      if (DATA_W < 1 || LEN_W < 1 || LAT_W < 1) begin : g_bad_width
         $error("DATA_W, LEN_W and LAT_W must be positive");
      end
      if (LAT_CYC < 0 || LAT_CYC >= (1 << LAT_W)) begin : g_bad_lat
         $error("LAT_CYC must fit in LAT_W bits");
      end
   endgenerate

   logic [LAT_W-1:0]  lat_eff;
   logic              m_we, m_whit, m_rhit;
   logic [ADDR_W-1:0] m_waddr, m_raddr;
   logic [DATA_W-1:0] m_wdata, m_rdata;

   generate
      if (LAT_FROM_PORT) begin : g_lat_port
         assign lat_eff = lat_cfg;
      end else begin : g_lat_fixed
         logic [LAT_W-1:0] unused_cfg;
         assign unused_cfg = lat_cfg;
         assign lat_eff    = LAT_W'(LAT_CYC);
      end
   endgenerate

   bmc_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_mem (
      .clk   (clk),
      .we    (m_we),
      .waddr (m_waddr),
      .wdata (m_wdata),
      .w_hit (m_whit),
      .raddr (m_raddr),
      .rdata (m_rdata),
      .r_hit (m_rhit)
   );

   bmc_wr_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LAT_W(LAT_W)) u_wr (
      .clk       (clk),
      .rst       (rst),
      .lat_val   (lat_eff),
      .aw_valid  (aw_valid),
      .aw_ready  (aw_ready),
      .aw_addr   (aw_addr),
      .aw_len    (aw_len),
      .w_valid   (w_valid),
      .w_ready   (w_ready),
      .w_data    (w_data),
      .b_valid   (b_valid),
      .b_ready   (b_ready),
      .b_resp    (b_resp),
      .mem_we    (m_we),
      .mem_addr  (m_waddr),
      .mem_wdata (m_wdata),
      .mem_hit   (m_whit)
   );

   bmc_rd_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LAT_W(LAT_W)) u_rd (
      .clk       (clk),
      .rst       (rst),
      .lat_val   (lat_eff),
      .ar_valid  (ar_valid),
      .ar_ready  (ar_ready),
      .ar_addr   (ar_addr),
      .ar_len    (ar_len),
      .r_valid   (r_valid),
      .r_ready   (r_ready),
      .r_data    (r_data),
      .r_resp    (r_resp),
      .r_last    (r_last),
      .mem_addr  (m_raddr),
      .mem_rdata (m_rdata),
      .mem_hit   (m_rhit)
   );
endmodule

// File: rtl/bmc_chk.sv
module bmc_chk #(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              aw_ready,
   input logic              ar_valid,
   input logic              ar_ready,
   input logic [LEN_W-1:0]  ar_len,
   input logic              b_valid,
   input logic              b_ready,
   input logic [1:0]        b_resp,
   input logic              r_valid,
   input logic              r_ready,
   input logic [DATA_W-1:0] r_data,
   input logic [1:0]        r_resp,
   input logic              r_last
);
   logic [LEN_W-1:0] rlen_q, rcnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         rlen_q <= '0;
         rcnt_q <= '0;
      end else if (ar_valid && ar_ready) begin
         rlen_q <= ar_len;
         rcnt_q <= '0;
      end else if (r_valid && r_ready) begin
         rcnt_q <= rcnt_q + 1'b1;
      end
   end

   // R7
   b_hold_chk: assert property (@(posedge clk) disable iff (rst)
      b_valid && !b_ready |=> b_valid && $stable(b_resp));

   // R7
   r_hold_chk: assert property (@(posedge clk) disable iff (rst)
      r_valid && !r_ready |=> r_valid && $stable(r_data) && $stable(r_resp) && $stable(r_last));

   // R8
   aw_block_chk: assert property (@(posedge clk) disable iff (rst)
      b_valid |-> !aw_ready);

   // R8
   ar_block_chk: assert property (@(posedge clk) disable iff (rst)
      r_valid |-> !ar_ready);

   // R5
   r_err_zero_chk: assert property (@(posedge clk) disable iff (rst)
      r_valid && (r_resp == 2'b10) |-> (r_data == '0));

   // R4
   b_code_chk: assert property (@(posedge clk) disable iff (rst)
      b_valid |-> (b_resp == 2'b00 || b_resp == 2'b10));

   // R2
   r_last_chk: assert property (@(posedge clk) disable iff (rst)
      r_valid |-> (r_last == (rcnt_q == rlen_q)));

   // R10
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> !b_valid && !r_valid && aw_ready && ar_ready);
endmodule

bind burst_mem_ctrl bmc_chk #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_chk (
   .clk      (clk),
   .rst      (rst),
   .aw_ready (aw_ready),
   .ar_valid (ar_valid),
   .ar_ready (ar_ready),
   .ar_len   (ar_len),
   .b_valid  (b_valid),
   .b_ready  (b_ready),
   .b_resp   (b_resp),
   .r_valid  (r_valid),
   .r_ready  (r_ready),
   .r_data   (r_data),
   .r_resp   (r_resp),
   .r_last   (r_last)
);

// File: tb/sim_burst_mem_ctrl.sv
`timescale 1ns/1ps
module sim_burst_mem_ctrl;
   localparam int DEPTH = 200;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [3:0]  lat_cfg = '0;
   logic        aw_valid = 1'b0, w_valid = 1'b0, b_ready = 1'b0;
   logic        ar_valid = 1'b0, r_ready = 1'b0;
   logic [7:0]  aw_addr = '0, ar_addr = '0;
   logic [3:0]  aw_len = '0, ar_len = '0;
   logic [31:0] w_data = '0;
   logic        aw_ready, w_ready, b_valid, ar_ready, r_valid, r_last;
   logic [1:0]  b_resp, r_resp;
   logic [31:0] r_data;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 1'b0;
   logic [31:0] model [0:255];

   // addr[15:8] len[7:4] lat[3:0]
   localparam logic [15:0] VECS [0:5] = '{
      16'h0A30, 16'h2802, 16'hC631, 16'hFA15, 16'h00FF, 16'h6473
   };

   always #2.5 clk = ~clk;

   burst_mem_ctrl u0 (
      .clk(clk), .rst(rst), .lat_cfg(lat_cfg),
      .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
      .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
      .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp),
      .ar_valid(ar_valid), .ar_ready(ar_ready), .ar_addr(ar_addr), .ar_len(ar_len),
      .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_resp(r_resp),
      .r_last(r_last)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic bit in_rng(input logic [7:0] a);
      return int'(a) < DEPTH;
   endfunction

   task automatic wr_burst(input logic [7:0] a, input logic [3:0] len,
                           input logic [3:0] lat, input logic [7:0] tag,
                           input int bdelay);
      bit any_err = 1'b0;
      logic [1:0] held;
      @(negedge clk);
      aw_valid = 1'b1; aw_addr = a; aw_len = len; lat_cfg = lat;
      while (!aw_ready) @(negedge clk);
      @(negedge clk);
      aw_valid = 1'b0;
      chk(!aw_ready, "R8", "aw_ready after write request", 32'(aw_ready), 0);
      for (int i = 0; i <= int'(len); i++) begin
         logic [7:0] ba;
         int cnt;
         ba = a + 8'(i);
         w_valid = 1'b1; w_data = {8'hA5, tag, ba, 8'(i)};
         while (!w_ready) @(negedge clk);
         @(negedge clk);
         w_valid = 1'b0;
         if (in_rng(ba)) model[ba] = {8'hA5, tag, ba, 8'(i)};
         else any_err = 1'b1;
         cnt = 0;
         while (!w_ready && !b_valid) begin
            @(negedge clk);
            cnt++;
         end
         chk(cnt == int'(lat) + 1, "R3", "write beat latency", 32'(cnt), 32'(int'(lat) + 1));
         chk(b_valid == (i == int'(len)), "R1", "response only after final beat",
             32'(b_valid), 32'(i == int'(len)));
      end
      chk(b_resp == (any_err ? 2'b10 : 2'b00), any_err ? "R4" : "R1", "write response",
          32'(b_resp), any_err ? 32'd2 : 32'd0);
      held = b_resp;
      for (int d = 0; d < bdelay; d++) begin
         @(negedge clk);
         chk(b_valid && b_resp == held && !aw_ready, "R7", "write response held",
             {b_valid, aw_ready, b_resp}, {1'b1, 1'b0, held});
      end
      b_ready = 1'b1;
      @(negedge clk);
      b_ready = 1'b0;
      chk(!b_valid && aw_ready, "R8", "write channel free after response",
          {b_valid, aw_ready}, 32'b01);
   endtask

   task automatic rd_burst(input logic [7:0] a, input logic [3:0] len,
                           input logic [3:0] lat, input int rdelay,
                           input bit poke_lat);
      @(negedge clk);
      ar_valid = 1'b1; ar_addr = a; ar_len = len; lat_cfg = lat;
      while (!ar_ready) @(negedge clk);
      @(negedge clk);
      ar_valid = 1'b0;
      if (poke_lat) lat_cfg = 4'd9;
      for (int i = 0; i <= int'(len); i++) begin
         logic [7:0]  ba;
         logic [31:0] exp_d, held_d;
         int cnt;
         ba = a + 8'(i);
         exp_d = in_rng(ba) ? model[ba] : 32'h0;
         cnt = 0;
         while (!r_valid) begin
            @(negedge clk);
            cnt++;
         end
         chk(cnt == int'(lat) + 1, "R3", "read beat latency", 32'(cnt), 32'(int'(lat) + 1));
         chk(r_data == exp_d, in_rng(ba) ? "R2" : "R5", "read data", r_data, exp_d);
         chk(r_resp == (in_rng(ba) ? 2'b00 : 2'b10), "R5", "read response",
             32'(r_resp), in_rng(ba) ? 32'd0 : 32'd2);
         chk(r_last == (i == int'(len)), "R2", "read last flag", 32'(r_last),
             32'(i == int'(len)));
         chk(!ar_ready, "R8", "ar_ready during read burst", 32'(ar_ready), 0);
         held_d = r_data;
         for (int d = 0; d < rdelay; d++) begin
            @(negedge clk);
            chk(r_valid && r_data == held_d, "R7", "read data held", r_data, held_d);
         end
         r_ready = 1'b1;
         @(negedge clk);
         r_ready = 1'b0;
      end
      chk(!r_valid && ar_ready, "R8", "read channel free after final beat",
          {r_valid, ar_ready}, 32'b01);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R10: reset state
      chk(aw_ready && ar_ready && !b_valid && !r_valid, "R10", "state after reset",
          {aw_ready, ar_ready, b_valid, r_valid}, 32'b1100);

      // table walk: R1 R2 R3 R4 R5 R6
      for (int v = 0; v < 6; v++) begin
         logic [7:0] va;
         logic [3:0] vl, vt;
         va = VECS[v][15:8]; vl = VECS[v][7:4]; vt = VECS[v][3:0];
         wr_burst(va, vl, vt, 8'(v), 0);
         rd_burst(va, vl, vt, 0, 1'b0);
      end

      // R7: delayed ready on both response paths
      wr_burst(8'd50, 4'd2, 4'd1, 8'h77, 3);
      rd_burst(8'd50, 4'd2, 4'd2, 2, 1'b0);

      // R3: latency change after request handshake has no effect
      rd_burst(8'd100, 4'd2, 4'd3, 0, 1'b1);

      // R6: address wrap past the top of the address space reads back low words
      rd_burst(8'hFF, 4'd2, 4'd0, 0, 1'b0);

      // R9: concurrent write and read bursts
      fork
         wr_burst(8'd150, 4'd3, 4'd2, 8'h99, 0);
         rd_burst(8'd10, 4'd3, 4'd2, 1, 1'b0);
      join
      rd_burst(8'd150, 4'd3, 4'd0, 0, 1'b0);

      // R10: reset in the middle of a write burst keeps stored words
      @(negedge clk);
      aw_valid = 1'b1; aw_addr = 8'd12; aw_len = 4'd1; lat_cfg = 4'd6;
      while (!aw_ready) @(negedge clk);
      @(negedge clk);
      aw_valid = 1'b0;
      w_valid = 1'b1; w_data = 32'hDEAD_BEEF;
      while (!w_ready) @(negedge clk);
      @(negedge clk);
      w_valid = 1'b0;
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(aw_ready && ar_ready && !b_valid && !r_valid, "R10", "state after mid-burst reset",
          {aw_ready, ar_ready, b_valid, r_valid}, 32'b1100);
      rd_burst(8'd12, 4'd1, 4'd0, 0, 1'b0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule